// File: doc/BRIEF.md
# SPI Frame Timer

This block produces the serial clock, the outgoing data line and the chip-select phase for one SPI master frame. Each frame is set up by a 32-bit timing attribute word. That word picks the frame length, the clock polarity and phase, the bit order, the serial clock period and two chip-select guard delays. It is sampled together with the parallel transmit word on a single start pulse. The block then runs on its own until the frame is complete.

The serial clock period and both guard delays are built the same way. Each is a small prescaler taken from a fixed table, multiplied by a scaler that is close to a power of two. This lets a single attribute word span roughly five decades of timing. When the frame is over, the block presents the received word and raises a one-cycle completion pulse. A new start may be given in that same cycle to chain frames with the shortest possible chip-select gap.

Top module: `spi_frame_timer`

## Requirements
- R1: The attribute word is decoded field by field as follows:
  - frame-size-minus-one in bits 30:27
  - clock polarity in bit 26
  - clock phase in bit 25
  - low-bit-first order in bit 24
  - lead-delay prescaler in bits 23:22
  - tail-delay prescaler in bits 21:20
  - clock prescaler in bits 17:16
  - lead-delay scaler in bits 15:12
  - tail-delay scaler in bits 11:8
  - clock scaler in bits 3:0
  
  All other bits are ignored.
- R2: The serial clock period in system clocks is the clock prescaler value times the clock scaler value:
  - Prescaler codes 0..3 give 2, 3, 5 and 7.
  - Scaler codes 0..3 give 2, 4, 6 and 8.
  - Scaler codes 4..15 give 2^code.
  
  Consecutive clock edges are half a period apart.
- R3: A start pulse seen while idle raises `cs_o` on the next cycle. The first clock edge comes L cycles after `cs_o` rises, where L = {1,3,5,7}[lead prescaler] × 2^(lead scaler+1).
- R4: `cs_o` falls T cycles after the last clock edge, where T = {1,3,5,7}[tail prescaler] × 2^(tail scaler+1).
- R5: A frame carries N bits and makes exactly 2N clock edges. N is the frame-size field plus one, from 4 to 16. Field values 0..2 are treated as 4 bits.
- R6: While idle, `sck_o` follows the polarity bit of `attr_i`, one cycle late. During a frame it rests at the latched polarity level outside its edges and is back at that level after the last edge.
- R7: The clock phase selects when data is driven and sampled:
  - Phase 0: the first bit is driven when `cs_o` rises, `miso_i` is sampled on odd edges, and the next bit is driven on even edges.
  - Phase 1: bits are driven on odd edges and `miso_i` is sampled on even edges.
- R8: With low-bit-first clear, bit k of the frame is `tx_data_i[N-1-k]`; with it set, bit k is `tx_data_i[k]`. Received bit k is placed at the same position in `rx_data_o`. Bits at N and above read zero.
- R9: `done_o` is high for exactly one cycle, in the same cycle that `cs_o` falls. `rx_data_o` updates in that cycle and holds until the next completion.
- R10: A start pulse while `cs_o` is high is ignored. Changes on `attr_i` or `tx_data_i` during a frame do not affect it.
- R11: A start pulse in the cycle where `done_o` is high is accepted, so `cs_o` is low for exactly one cycle between the two frames.
- R12: `mosi_o` is low whenever `cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start one frame (taken only when idle or in the completion cycle) |
| attr_i | input | ATTR_W | Timing attribute word |
| tx_data_i | input | MAX_BITS | Parallel word to transmit |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 1 | Chip-select phase, high while a frame is active |
| rx_data_o | output | MAX_BITS | Last received word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can fall in the same cycle: the completion pulse with its chip-select release, and the acceptance of the next start. To provoke this, the bench asserts start exactly in the cycle where `done_o` is seen, with a different attribute word and data. It then checks three things:
- `cs_o` was low for just that one cycle;
- the first frame's received word was published intact;
- the second frame meets its own edge count, delays and data.

A further directed frame asserts start and scrambles the attribute and data inputs in the middle of a frame. That frame must still complete with its original timing and contents.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

  // attribute field positions (neighbour logic decodes these)
  localparam int unsigned FS_HI   = 30;
  localparam int unsigned FS_LO   = 27;
  localparam int unsigned POL_B   = 26;
  localparam int unsigned PHA_B   = 25;
  localparam int unsigned LSB_B   = 24;
  localparam int unsigned LPRE_LO = 22;
  localparam int unsigned TPRE_LO = 20;
  localparam int unsigned BPRE_LO = 16;
  localparam int unsigned LSCL_LO = 12;
  localparam int unsigned TSCL_LO = 8;
  localparam int unsigned BSCL_LO = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } tm_state_e;

  // clock prescaler: 2, 3, 5, 7
  function automatic logic [2:0] clk_pre(input logic [1:0] c);
    case (c)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  // clock scaler: linear steps of two below code 4, powers of two above
  function automatic logic [15:0] clk_scl(input logic [3:0] c);
    logic [3:0] inc;
    inc = c + 4'd1;
    if (c < 4'd4) return {11'd0, inc, 1'b0};
    return 16'd1 << c;
  endfunction

  // delay prescaler: the odd values 1, 3, 5, 7
  function automatic logic [2:0] dly_pre(input logic [1:0] c);
    return {c, 1'b1};
  endfunction

endpackage

// File: rtl/spi_tm_divsel.sv
module spi_tm_divsel
  import spi_tm_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int ATTR_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic [ATTR_W-1:0] attr_i,
  output logic [CNT_W-1:0]  half_m1_o,
  output logic [CNT_W-1:0]  lead_m1_o,
  output logic [CNT_W-1:0]  trail_m1_o,
  output logic [BIT_W-1:0]  nbits_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic              lsb_o
);

  logic [31:0] period, half, lead, trail;
  logic [4:0]  fs;
  logic [4:0]  nb;

  always_comb begin
    period = 32'(clk_pre(attr_i[BPRE_LO +: 2])) * 32'(clk_scl(attr_i[BSCL_LO +: 4]));
    half   = period >> 1;
    lead   = 32'(dly_pre(attr_i[LPRE_LO +: 2])) << (32'(attr_i[LSCL_LO +: 4]) + 32'd1);
    trail  = 32'(dly_pre(attr_i[TPRE_LO +: 2])) << (32'(attr_i[TSCL_LO +: 4]) + 32'd1);
    fs     = {1'b0, attr_i[FS_HI:FS_LO]};
    nb     = (fs < 5'd3) ? 5'd4 : fs + 5'd1;
  end

  assign half_m1_o  = CNT_W'(half - 32'd1);
  assign lead_m1_o  = CNT_W'(lead - 32'd1);
  assign trail_m1_o = CNT_W'(trail - 32'd1);
  assign nbits_o    = BIT_W'(nb);
  assign cpol_o     = attr_i[POL_B];
  assign cpha_o     = attr_i[PHA_B];
  assign lsb_o      = attr_i[LSB_B];

endmodule

// File: rtl/spi_tm_downcnt.sv
module spi_tm_downcnt #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)               q <= '0;
    else if (load_i)       q <= load_val_i;
    else if (q != '0)      q <= q - W'(1);
  end

  assign zero_o = (q == '0);

endmodule

// File: rtl/spi_tm_shifter.sv
module spi_tm_shifter #(
  parameter int MAX_BITS = 16,
  parameter int BIT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [BIT_W-1:0]    cfg_nbits_i,
  input  logic                cfg_lsb_i,
  input  logic [MAX_BITS-1:0] tx_i,
  input  logic                drive_i,
  input  logic                samp_i,
  input  logic                clr_i,
  input  logic                miso_i,
  output logic                mosi_o,
  output logic [MAX_BITS-1:0] rx_o
);

  localparam int IDX_W = $clog2(MAX_BITS);
  localparam logic [BIT_W-1:0] ONE = BIT_W'(1);

  logic [MAX_BITS-1:0] tx_r, rx_r;
  logic [BIT_W-1:0]    nbits_r, drv_cnt, samp_cnt;
  logic                lsb_r, mosi_q;

  function automatic logic [IDX_W-1:0] bit_pos(input logic [BIT_W-1:0] k,
                                               input logic [BIT_W-1:0] n,
                                               input logic             lsb);
    logic [BIT_W-1:0] p;
    p = lsb ? k : (n - k - ONE);
    return p[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_r     <= '0;
      rx_r     <= '0;
      nbits_r  <= '0;
      lsb_r    <= 1'b0;
      drv_cnt  <= '0;
      samp_cnt <= '0;
      mosi_q   <= 1'b0;
    end else if (load_i) begin
      tx_r     <= tx_i;
      rx_r     <= '0;
      nbits_r  <= cfg_nbits_i;
      lsb_r    <= cfg_lsb_i;
      samp_cnt <= '0;
      if (drive_i) begin
        mosi_q  <= tx_i[bit_pos('0, cfg_nbits_i, cfg_lsb_i)];
        drv_cnt <= ONE;
      end else begin
        mosi_q  <= 1'b0;
        drv_cnt <= '0;
      end
    end else begin
      if (drive_i) begin
        mosi_q  <= tx_r[bit_pos(drv_cnt, nbits_r, lsb_r)];
        drv_cnt <= drv_cnt + ONE;
      end
      if (samp_i) begin
        rx_r[bit_pos(samp_cnt, nbits_r, lsb_r)] <= miso_i;
        samp_cnt <= samp_cnt + ONE;
      end
      if (clr_i) mosi_q <= 1'b0;
    end
  end

  assign mosi_o = mosi_q;
  assign rx_o   = rx_r;

  AST_DRIVE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (drive_i && !load_i) |-> (drv_cnt < nbits_r)); // R5
  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (samp_i && !load_i) |-> (samp_cnt < nbits_r)); // R5

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
  import spi_tm_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int CNT_W    = 20,
  parameter int ATTR_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [ATTR_W-1:0]   attr_i,
  input  logic [MAX_BITS-1:0] tx_data_i,
  input  logic                miso_i,
  output logic                sck_o,
  output logic                mosi_o,
  output logic                cs_o,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                done_o
);

  localparam int BIT_W  = $clog2(MAX_BITS + 1);
  localparam int EDGE_W = BIT_W + 1;
  localparam logic [EDGE_W-1:0] ONE_E = EDGE_W'(1);

  // decoded attribute (combinational, latched at start)
  logic [CNT_W-1:0] d_half_m1, d_lead_m1, d_trail_m1;
  logic [BIT_W-1:0] d_nbits;
  logic             d_cpol, d_cpha, d_lsb;

  spi_tm_divsel #(.CNT_W(CNT_W), .ATTR_W(ATTR_W), .BIT_W(BIT_W)) u_div (
    .attr_i     (attr_i),
    .half_m1_o  (d_half_m1),
    .lead_m1_o  (d_lead_m1),
    .trail_m1_o (d_trail_m1),
    .nbits_o    (d_nbits),
    .cpol_o     (d_cpol),
    .cpha_o     (d_cpha),
    .lsb_o      (d_lsb)
  );

  tm_state_e        st;
  logic [CNT_W-1:0] half_m1_r, trail_m1_r;
  logic [BIT_W-1:0] nbits_r;
  logic             cpol_r, cpha_r;
  logic [EDGE_W-1:0] edge_cnt_r;
  logic             sck_q, cs_q, done_q;
  logic [MAX_BITS-1:0] rx_q;

  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             take_start, edge_now, last_edge, odd_edge;
  logic [EDGE_W-1:0] edge_num;
  logic             sh_drive, sh_samp, sh_clr;
  logic [MAX_BITS-1:0] sh_rx;

  always_comb begin
    take_start = (st == ST_IDLE) && start_i;
    edge_now   = ((st == ST_LEAD) || (st == ST_SHIFT)) && cnt_zero;
    edge_num   = edge_cnt_r + ONE_E;
    odd_edge   = edge_num[0];
    last_edge  = (edge_num == {nbits_r, 1'b0});

    cnt_load = 1'b0;
    cnt_val  = '0;
    if (take_start) begin
      cnt_load = 1'b1;
      cnt_val  = d_lead_m1;
    end else if (edge_now) begin
      cnt_load = 1'b1;
      cnt_val  = last_edge ? trail_m1_r : half_m1_r;
    end

    if (take_start)    sh_drive = !d_cpha;
    else if (edge_now) sh_drive = cpha_r ? odd_edge : (!odd_edge && !last_edge);
    else               sh_drive = 1'b0;
    sh_samp = edge_now && (cpha_r ? !odd_edge : odd_edge);
    sh_clr  = (st == ST_TRAIL) && cnt_zero;
  end

  spi_tm_downcnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  spi_tm_shifter #(.MAX_BITS(MAX_BITS), .BIT_W(BIT_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load_i      (take_start),
    .cfg_nbits_i (d_nbits),
    .cfg_lsb_i   (d_lsb),
    .tx_i        (tx_data_i),
    .drive_i     (sh_drive),
    .samp_i      (sh_samp),
    .clr_i       (sh_clr),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_o        (sh_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      half_m1_r  <= '0;
      trail_m1_r <= '0;
      nbits_r    <= '0;
      cpol_r     <= 1'b0;
      cpha_r     <= 1'b0;
      edge_cnt_r <= '0;
      sck_q      <= 1'b0;
      cs_q       <= 1'b0;
      done_q     <= 1'b0;
      rx_q       <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          sck_q <= d_cpol;
          if (start_i) begin
            half_m1_r  <= d_half_m1;
            trail_m1_r <= d_trail_m1;
            nbits_r    <= d_nbits;
            cpol_r     <= d_cpol;
            cpha_r     <= d_cpha;
            edge_cnt_r <= '0;
            cs_q       <= 1'b1;
            st         <= ST_LEAD;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (cnt_zero) begin
            sck_q      <= ~sck_q;
            edge_cnt_r <= edge_num;
            st         <= last_edge ? ST_TRAIL : ST_SHIFT;
          end
        end
        default: begin
          if (cnt_zero) begin
            cs_q   <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= sh_rx;
            st     <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign sck_o     = sck_q;
  assign cs_o      = cs_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;

  AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cs_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_CS_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_o) |-> $past(start_i)); // R3
  AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TRAIL) |-> (sck_o == cpol_r)); // R6
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs_o |-> !mosi_o); // R12
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SHIFT) |-> (edge_cnt_r < {nbits_r, 1'b0})); // R5
  AST_NBITS_RANGE: assert property (@(posedge clk) disable iff (rst)
    cs_o |-> ((nbits_r >= BIT_W'(4)) && (nbits_r <= BIT_W'(MAX_BITS)))); // R5

endmodule

// File: tb/tb_spi_frame_timer.sv
module tb_spi_frame_timer;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] attr_i = '0;
  logic [15:0] tx_data_i = '0;
  logic        miso_i = 1'b0;
  logic        sck_o, mosi_o, cs_o, done_o;
  logic [15:0] rx_data_o;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  spi_frame_timer dut (
    .clk(clk), .rst(rst), .start_i(start_i), .attr_i(attr_i),
    .tx_data_i(tx_data_i), .miso_i(miso_i), .sck_o(sck_o),
    .mosi_o(mosi_o), .cs_o(cs_o), .rx_data_o(rx_data_o), .done_o(done_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int e_n(input logic [31:0] a);
    int f = int'(a[30:27]);
    return (f < 3) ? 4 : f + 1;
  endfunction

  function automatic int e_half(input logic [31:0] a);
    int pt[4] = '{2, 3, 5, 7};
    int st[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                   4096, 8192, 16384, 32768};
    return (pt[a[17:16]] * st[a[3:0]]) / 2;
  endfunction

  function automatic int e_dly(input logic [1:0] p, input logic [3:0] s);
    int pt[4] = '{1, 3, 5, 7};
    return pt[p] * (2 ** (int'(s) + 1));
  endfunction

  function automatic int pos(input int k, input int n, input bit lsb);
    return lsb ? k : n - 1 - k;
  endfunction

  function automatic logic [31:0] mk(input int fs, input bit pol, input bit pha,
                                     input bit lsb, input int lp, input int ls,
                                     input int tp, input int ts, input int bp,
                                     input int bs);
    logic [31:0] a = '0;
    a[30:27] = 4'(fs); a[26] = pol; a[25] = pha; a[24] = lsb;
    a[23:22] = 2'(lp); a[21:20] = 2'(tp); a[17:16] = 2'(bp);
    a[15:12] = 4'(ls); a[11:8] = 4'(ts); a[3:0] = 4'(bs);
    return a;
  endfunction

  // issue start from idle; returns at the negedge of the cycle cs should rise
  task automatic kick(input logic [31:0] a, input logic [15:0] tx);
    @(negedge clk);
    attr_i = a;
    @(negedge clk);
    chk(sck_o == a[26], "R6", "idle sck follows polarity", int'(sck_o), int'(a[26]));
    tx_data_i = tx;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // observe one frame starting at its first cs-high cycle
  task automatic watch(input logic [31:0] a, input logic [15:0] tx,
                       input logic [15:0] sl, input bit disturb,
                       input bit chain, input logic [31:0] na,
                       input logic [15:0] ntx);
    int n = e_n(a);
    int h = e_half(a);
    int l = e_dly(a[23:22], a[15:12]);
    int t = e_dly(a[21:20], a[11:8]);
    bit pol = a[26], pha = a[25], lsb = a[24];
    logic [15:0] mask = 16'((32'd1 << n) - 1);
    logic [15:0] srx = '0;
    int e = 0, first = -1, last = -1, gaps = 0, scnt = 0, cyc = 0, fall = -1;
    bit prev, seen = 1'b0;
    string rq = disturb ? "R10" : "R8";

    chk(cs_o == 1'b1, "R3", "cs one cycle after start", int'(cs_o), 1);
    chk(sck_o == pol, "R6", "sck at polarity on frame start", int'(sck_o), int'(pol));
    if (!pha) miso_i = sl[pos(0, n, lsb)];
    prev = sck_o;
    while (!seen && cyc < 250000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        start_i = 1'b1;
        attr_i = a ^ 32'h7900_0f0f;
        tx_data_i = ~tx;
      end
      if (disturb && cyc == 3) start_i = 1'b0;
      if (sck_o != prev) begin
        e++;
        prev = sck_o;
        if (e == 1) first = cyc;
        else if (cyc - last != h) gaps++;
        last = cyc;
        if ((pha && (e % 2 == 0)) || (!pha && (e % 2 == 1))) begin
          if (scnt < n) srx[pos(scnt, n, lsb)] = mosi_o;
          scnt++;
        end
        if (!pha && (e % 2 == 0) && e < 2 * n) miso_i = sl[pos(e / 2, n, lsb)];
        if (pha && (e % 2 == 1)) miso_i = sl[pos((e - 1) / 2, n, lsb)];
      end
      if (!cs_o && fall < 0) fall = cyc;
      if (done_o) seen = 1'b1;
    end
    chk(seen, "R9", "done seen", int'(seen), 1);
    chk(fall == cyc, "R9", "cs falls in done cycle", fall, cyc);
    chk(e == 2 * n, "R5", "edge count", e, 2 * n);
    chk(first == l, "R3", "lead delay", first, l);
    chk(gaps == 0, "R2 R1", "half-period gaps off", gaps, 0);
    chk(cyc - last == t, "R4", "tail delay", cyc - last, t);
    chk(sck_o == pol, "R6", "sck back at polarity", int'(sck_o), int'(pol));
    chk(mosi_o == 1'b0, "R12", "mosi low after frame", int'(mosi_o), 0);
    chk(rx_data_o == (sl & mask), rq, "received word", int'(rx_data_o), int'(sl & mask));
    chk(srx == (tx & mask), "R7", "word seen by slave", int'(srx), int'(tx & mask));
    if (chain) begin
      attr_i = na;
      tx_data_i = ntx;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(cs_o == 1'b1, "R11", "cs low only one cycle", int'(cs_o), 1);
    end else begin
      @(negedge clk);
      chk(done_o == 1'b0, "R9", "done single cycle", int'(done_o), 0);
      chk(rx_data_o == (sl & mask), "R9", "rx held", int'(rx_data_o), int'(sl & mask));
      chk(mosi_o == 1'b0, "R12", "mosi idle", int'(mosi_o), 0);
    end
  endtask

  task automatic frame(input logic [31:0] a, input logic [15:0] tx,
                       input logic [15:0] sl, input bit disturb);
    kick(a, tx);
    watch(a, tx, sl, disturb, 1'b0, '0, '0);
  endtask

  initial begin
    logic [31:0] a2;
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_o == 1'b0, "R12", "reset cs", int'(cs_o), 0);
    chk(mosi_o == 1'b0, "R12", "reset mosi", int'(mosi_o), 0);
    chk(done_o == 1'b0, "R9", "reset done", int'(done_o), 0);
    chk(rx_data_o == 16'h0, "R9", "reset rx", int'(rx_data_o), 0);
    chk(sck_o == 1'b0, "R6", "reset sck", int'(sck_o), 0);

    // R2 R5 fastest clock, full 16-bit msb-first frame
    frame(mk(15, 0, 0, 0, 0, 0, 0, 0, 0, 0), 16'hA5C3, 16'h3C5A, 1'b0);
    // R7 R8 phase 1, polarity 1, low-bit-first, 8 bits
    frame(mk(7, 1, 1, 1, 1, 2, 2, 1, 1, 2), 16'h00D2, 16'h0096, 1'b0);
    // R5 short field clamps to 4 bits
    frame(mk(1, 0, 0, 1, 0, 1, 3, 0, 2, 1), 16'hFFF9, 16'hBEE6, 1'b0);
    // R3 long lead delay, slow clock
    frame(mk(4, 1, 0, 0, 3, 9, 0, 0, 3, 4), 16'h0015, 16'h000A, 1'b0);
    // R10 start and input changes in mid-frame
    frame(mk(11, 0, 1, 0, 1, 1, 1, 1, 1, 3), 16'h0A3C, 16'h05C3, 1'b1);
    // R11 start in the completion cycle
    a2 = mk(9, 1, 0, 1, 2, 0, 0, 2, 2, 0);
    kick(mk(5, 0, 1, 0, 0, 0, 0, 0, 0, 1), 16'h002B);
    watch(mk(5, 0, 1, 0, 0, 0, 0, 0, 0, 1), 16'h002B, 16'h0031, 1'b0, 1'b1, a2, 16'h0317);
    watch(a2, 16'h0317, 16'h02C8, 1'b0, 1'b0, '0, '0);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = mk(int'($urandom % 16), bit'($urandom % 2), bit'($urandom % 2),
             bit'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
             int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
             int'($urandom % 5));
      frame(a, 16'($urandom), 16'($urandom), 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule